// File: doc/BRIEF.md
# Write Target Ready Sequencer

This block sits inside a memory-controller target on a shared front-side data bus. It decides when to raise the target-ready signal that tells a data source it may take the data bus. A write from a requester gets one target-ready handshake once a small write buffer is free. A transaction whose snoop reports a modified-line hit also needs a second handshake. That second handshake is for the snooping cache's full 64-byte writeback line, and it waits for a line buffer.

The width of each target-ready pulse depends on the data-busy level sampled at the edge that raises it. If the bus was free at that edge, the pulse lasts one cycle. If the bus was busy, the pulse stays high until data-busy is sampled low, and then for one more cycle. The block also tracks the transaction's own response. Target-ready is never high in a response cycle. One cycle after the response of a write, the block signals whether the buffered write data is to be committed or thrown away.

Top module: `trdy_ctrl`

## Requirements
- R1: After reset, `trdy`, `wr_commit` and `wr_discard` are low.
- R2: Take E0 as the clock edge that samples `ads` high while the block is idle. `trdy` is first high no earlier than the cycle that follows edge E0+3, which is the third edge after E0.
- R3: `trdy` rises for a requester write only if `part_buf_rdy` was sampled high at the rising edge. It rises for a writeback line only if `line_buf_rdy` was sampled high at that edge.
- R4: `trdy` rises only if `prev_rsp_done` was sampled high at the rising edge.
- R5: If `dbsy` was sampled low at the edge that raises `trdy`, then `trdy` is high for exactly one cycle.
- R6: If `dbsy` was sampled high at that edge, then `trdy` stays high until `dbsy` is sampled low. It stays high for the cycle after that sample and falls at the following edge.
- R7: `trdy` is low in any cycle where `rsp_now` is high. A response sampled during a handshake ends that handshake.
- R8: A write whose snoop reports a hit (`snp_vld` and `snp_hitm` high together) gets a second `trdy` pulse after at least one low cycle, gated by `line_buf_rdy`. A write whose snoop reports a miss gets only one pulse.
- R9: A read gets no requester handshake. A read that snoops a hit gets one writeback pulse, and a read that snoops a miss gets none.
- R10: For a write, the edge that samples `rsp_now` high makes `wr_commit` high for one cycle if `rsp_fail` is low, or `wr_discard` high for one cycle if `rsp_fail` is high.
- R11: A transaction returns to idle, and accepts a new `ads`, only once its snoop result is known and every handshake it needs has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads | input | 1 | Request strobe, taken only when idle |
| ads_wr | input | 1 | Request is a write (1) or a read (0), valid with `ads` |
| snp_vld | input | 1 | Snoop result delivered this cycle |
| snp_hitm | input | 1 | Snoop hit a modified line, valid with `snp_vld` |
| part_buf_rdy | input | 1 | Buffer for up to 32 bytes of requester data is free |
| line_buf_rdy | input | 1 | 64-byte line buffer is free |
| dbsy | input | 1 | Data bus busy, as seen on the bus |
| prev_rsp_done | input | 1 | The previous transaction's response has been seen |
| rsp_now | input | 1 | This transaction's response is driven this cycle |
| rsp_fail | input | 1 | The response being driven is a hard failure |
| trdy | output | 1 | Target ready to accept data |
| wr_commit | output | 1 | Buffered write data may be committed |
| wr_discard | output | 1 | Buffered write data must be dropped |

## Verification
Every decision is made at a clock edge and lands in a register, so a stimulus sampled at one edge shows on `trdy` in the cycle that follows it. Only `rsp_now` acts at once, because it masks `trdy` in its own cycle. The commit and discard outputs appear one edge after the response. The bench drives inputs on falling edges and advances a behavioural model at each rising edge. It compares the model's outputs 5 ns after that edge. Rise times are measured against the sampled strobe edge, for example exactly three edges for the earliest handshake. Pulse widths are counted in whole cycles.

// File: rtl/trdy_ctrl.sv
module trdy_ctrl #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ads,
  input  logic ads_wr,
  input  logic snp_vld,
  input  logic snp_hitm,
  input  logic part_buf_rdy,
  input  logic line_buf_rdy,
  input  logic dbsy,
  input  logic prev_rsp_done,
  input  logic rsp_now,
  input  logic rsp_fail,
  output logic trdy,
  output logic wr_commit,
  output logic wr_discard
);
  localparam int CW = $clog2(GAP + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_EL, ST_ASSERT, ST_HOLD, ST_DROP, ST_WAIT_SEC
  } st_t;

  st_t state, nxt;
  logic [CW-1:0] cnt;
  logic wr_q, snp_seen, hitm_seen, phase2, dbsy_first;

  logic idle_w, age_ok, seen_now, hit_now, go_assert, done_st;
  assign idle_w   = (state == ST_IDLE);
  assign age_ok   = (cnt >= CW'(GAP));
  assign seen_now = snp_seen | snp_vld;
  assign hit_now  = hitm_seen | (snp_vld & snp_hitm);
  assign go_assert = (nxt == ST_ASSERT) && (state != ST_ASSERT);
  assign done_st  = phase2;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (ads) nxt = ST_WAIT_EL;
      ST_WAIT_EL: begin
        if (!wr_q) nxt = ST_WAIT_SEC;
        else if (age_ok && part_buf_rdy && prev_rsp_done && !rsp_now) nxt = ST_ASSERT;
      end
      ST_ASSERT: begin
        if (rsp_now || !dbsy_first) nxt = done_st ? ST_IDLE : ST_WAIT_SEC;
        else if (!dbsy)             nxt = ST_DROP;
        else                        nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (rsp_now)    nxt = done_st ? ST_IDLE : ST_WAIT_SEC;
        else if (!dbsy) nxt = ST_DROP;
      end
      ST_DROP:    nxt = done_st ? ST_IDLE : ST_WAIT_SEC;
      ST_WAIT_SEC: begin
        if (seen_now && !hit_now) nxt = ST_IDLE;
        else if (hit_now && age_ok && line_buf_rdy && prev_rsp_done && !rsp_now)
          nxt = ST_ASSERT;
      end
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      wr_q       <= 1'b0;
      snp_seen   <= 1'b0;
      hitm_seen  <= 1'b0;
      phase2     <= 1'b0;
      dbsy_first <= 1'b0;
      wr_commit  <= 1'b0;
      wr_discard <= 1'b0;
    end else begin
      state      <= nxt;
      wr_commit  <= rsp_now & ~rsp_fail & wr_q;
      wr_discard <= rsp_now &  rsp_fail & wr_q;
      if (go_assert) dbsy_first <= dbsy;
      if (idle_w && ads) begin
        cnt       <= CW'(1);
        wr_q      <= ads_wr;
        snp_seen  <= 1'b0;
        hitm_seen <= 1'b0;
        phase2    <= 1'b0;
      end else begin
        if (!age_ok) cnt <= cnt + 1'b1;
        if (!idle_w && snp_vld) begin
          snp_seen  <= 1'b1;
          hitm_seen <= hitm_seen | snp_hitm;
        end
        if (state == ST_WAIT_SEC && go_assert) phase2 <= 1'b1;
        if (!idle_w && nxt == ST_IDLE) begin
          hitm_seen <= 1'b0;
          phase2    <= 1'b0;
        end
      end
    end
  end

  assign trdy = (state == ST_ASSERT || state == ST_HOLD || state == ST_DROP) && !rsp_now;
endmodule

// File: rtl/trdy_ctrl_chk.sv
module trdy_ctrl_chk #(
  parameter int GAP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ads,
  input logic idle_i,
  input logic second_i,
  input logic part_buf_rdy,
  input logic line_buf_rdy,
  input logic dbsy,
  input logic prev_rsp_done,
  input logic rsp_now,
  input logic rsp_fail,
  input logic trdy,
  input logic wr_commit,
  input logic wr_discard
);
  logic [7:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (idle_i && ads) age <= '0;
    else if (age < 8'(GAP)) age <= age + 8'd1;
  end

  AST_MIN_GAP:   assert property (@(posedge clk) disable iff (!rst_n)
    trdy |-> (age >= 8'(GAP)));                                          // R2
  AST_BUF_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy) |-> (second_i ? $past(line_buf_rdy) : $past(part_buf_rdy))); // R3
  AST_PREV_RSP:  assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy) |-> $past(prev_rsp_done));                               // R4
  AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trdy) && !$past(dbsy)) |=> !trdy);                            // R5
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy && $past(trdy) && $past(dbsy) && dbsy && !rsp_now) |=> (trdy || rsp_now)); // R6
  AST_DROP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy && $past(trdy) && !$past(dbsy)) |=> !trdy);                    // R6
  AST_COMMIT:    assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(rsp_now && !rsp_fail));                          // R10
  AST_DISCARD:   assert property (@(posedge clk) disable iff (!rst_n)
    wr_discard |-> $past(rsp_now && rsp_fail));                          // R10
endmodule

bind trdy_ctrl trdy_ctrl_chk #(.GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ads(ads), .idle_i(idle_w), .second_i(phase2),
  .part_buf_rdy(part_buf_rdy), .line_buf_rdy(line_buf_rdy), .dbsy(dbsy),
  .prev_rsp_done(prev_rsp_done), .rsp_now(rsp_now), .rsp_fail(rsp_fail),
  .trdy(trdy), .wr_commit(wr_commit), .wr_discard(wr_discard)
);

// File: tb/sim_trdy_ctrl.sv
`timescale 1ns/1ps
module sim_trdy_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ads = 0, ads_wr = 0, snp_vld = 0, snp_hitm = 0;
  logic part_buf_rdy = 1, line_buf_rdy = 1, dbsy = 0, prev_rsp_done = 1;
  logic rsp_now = 0, rsp_fail = 0;
  logic trdy, wr_commit, wr_discard;

  always #10 clk = ~clk;

  trdy_ctrl u0 (.clk(clk), .rst_n(rst_n), .ads(ads), .ads_wr(ads_wr),
    .snp_vld(snp_vld), .snp_hitm(snp_hitm), .part_buf_rdy(part_buf_rdy),
    .line_buf_rdy(line_buf_rdy), .dbsy(dbsy), .prev_rsp_done(prev_rsp_done),
    .rsp_now(rsp_now), .rsp_fail(rsp_fail), .trdy(trdy),
    .wr_commit(wr_commit), .wr_discard(wr_discard));

  int checks = 0, errors = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 first wait, 2 writeback wait, 3 pulse
  int cyc = 0, ads_cyc = 0, age = 0, phase = 0;
  bit m_wr, m_seen, m_hit, m_p2, m_end, m_cmt, m_dsc;
  int npulse = 0, width = 0, rise_cyc = 0;
  bit last_trdy = 0;

  task automatic finish_pulse();
    if (m_p2) begin phase = 0; m_hit = 0; m_p2 = 0; end
    else phase = 2;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      phase = 0; m_cmt = 0; m_dsc = 0; m_wr = 0; m_p2 = 0; m_hit = 0;
    end else begin
      m_cmt = rsp_now && !rsp_fail && m_wr;
      m_dsc = rsp_now && rsp_fail && m_wr;
      if (phase != 0 && snp_vld) begin m_seen = 1; m_hit = m_hit | snp_hitm; end
      case (phase)
        0: if (ads) begin
             phase = 1; age = 0; m_wr = ads_wr; m_seen = 0; m_hit = 0; m_p2 = 0;
             ads_cyc = cyc;
           end
        1: if (!m_wr) phase = 2;
           else if (age >= 3 && part_buf_rdy && prev_rsp_done && !rsp_now) begin
             phase = 3; m_end = !dbsy;
           end
        3: if (rsp_now || m_end) finish_pulse();
           else if (!dbsy) m_end = 1;
        2: if (m_seen && !m_hit) phase = 0;
           else if (m_hit && age >= 3 && line_buf_rdy && prev_rsp_done && !rsp_now) begin
             phase = 3; m_p2 = 1; m_end = !dbsy;
           end
        default: phase = 0;
      endcase
      if (age < 3) age++;
    end
    #5;
    if (rst_n) begin
      chk(trdy === ((phase == 3) && !rsp_now), tag, trdy, (phase == 3) && !rsp_now);
      chk({wr_commit, wr_discard} === {m_cmt, m_dsc}, tag,
          {wr_commit, wr_discard}, {m_cmt, m_dsc});
      if (trdy && !last_trdy) begin npulse++; rise_cyc = cyc; width = 0; end
      if (trdy) width++;
      last_trdy = trdy;
    end
  end

  task automatic go_req(input bit wr);
    ads = 1; ads_wr = wr; @(negedge clk); ads = 0;
  endtask
  task automatic snoop(input bit hit);
    snp_vld = 1; snp_hitm = hit; @(negedge clk); snp_vld = 0; snp_hitm = 0;
  endtask
  task automatic respond(input bit fail, input string req, input bit wr);
    rsp_now = 1; rsp_fail = fail;
    @(posedge clk); #5;
    chk(trdy === 1'b0, "R7", trdy, 0);
    chk(wr_commit === (wr && !fail), req, wr_commit, wr && !fail);
    chk(wr_discard === (wr && fail), req, wr_discard, wr && fail);
    @(negedge clk); rsp_now = 0; rsp_fail = 0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(trdy === 1'b0 && wr_commit === 1'b0 && wr_discard === 1'b0, "R1",
        {trdy, wr_commit, wr_discard}, 0);
    rst_n = 1; @(negedge clk);

    tag = "R2"; base = npulse;          // earliest single-cycle handshake
    go_req(1); snoop(0); repeat (6) @(negedge clk);
    chk(rise_cyc - ads_cyc == 3, "R2", rise_cyc - ads_cyc, 3);
    chk(width == 1, "R5", width, 1);
    chk(npulse - base == 1, "R8", npulse - base, 1);
    tag = "R10"; respond(0, "R10", 1); repeat (2) @(negedge clk);

    tag = "R3"; part_buf_rdy = 0; base = npulse;
    go_req(1); snoop(0); repeat (4) @(negedge clk);
    chk(npulse == base, "R3", npulse - base, 0);
    part_buf_rdy = 1; repeat (4) @(negedge clk);
    chk(rise_cyc - ads_cyc == 6, "R3", rise_cyc - ads_cyc, 6);
    repeat (2) @(negedge clk);

    tag = "R4"; prev_rsp_done = 0; base = npulse;
    go_req(1); snoop(0); repeat (5) @(negedge clk);
    chk(npulse == base, "R4", npulse - base, 0);
    prev_rsp_done = 1; repeat (4) @(negedge clk);
    chk(npulse - base == 1, "R4", npulse - base, 1);
    repeat (2) @(negedge clk);

    tag = "R6"; dbsy = 1;
    go_req(1); snoop(0); repeat (3) @(negedge clk);
    dbsy = 0; repeat (5) @(negedge clk);
    chk(width == 3, "R6", width, 3);

    tag = "R7"; dbsy = 1; base = npulse;
    go_req(1); snoop(0); repeat (2) @(negedge clk);
    chk(trdy === 1'b1, "R7", trdy, 1);
    respond(1, "R10", 1);
    dbsy = 0; repeat (4) @(negedge clk);
    chk(npulse - base == 1, "R7", npulse - base, 1);
    chk(trdy === 1'b0, "R11", trdy, 0);

    tag = "R8"; line_buf_rdy = 0; base = npulse;
    go_req(1); snoop(1); repeat (6) @(negedge clk);
    chk(npulse - base == 1, "R8", npulse - base, 1);
    line_buf_rdy = 1; repeat (4) @(negedge clk);
    chk(npulse - base == 2, "R8", npulse - base, 2);
    tag = "R10"; respond(0, "R10", 1); repeat (2) @(negedge clk);

    tag = "R9"; base = npulse;
    go_req(0); snoop(1); repeat (8) @(negedge clk);
    chk(npulse - base == 1, "R9", npulse - base, 1);
    respond(0, "R10", 0);
    base = npulse;
    go_req(0); snoop(0); repeat (8) @(negedge clk);
    chk(npulse - base == 0, "R9", npulse - base, 0);

    tag = "R11"; base = npulse;        // strobe while busy is not a new request
    go_req(1); repeat (2) @(negedge clk); go_req(0);
    repeat (6) @(negedge clk);
    chk(npulse - base == 1 && trdy === 1'b0, "R11", npulse - base, 1);
    snoop(0); repeat (3) @(negedge clk);
    base = npulse; go_req(1); snoop(0); repeat (6) @(negedge clk);
    chk(npulse - base == 1, "R11", npulse - base, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule